// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Controller

This block turns 32 already-synchronized GPIO input levels into latched interrupt events. Each pin has its own 4-bit detection code, which picks a rising edge, a falling edge, either edge, a high level or a low level. A per-pin acceptance gate decides whether detected events may latch at all. Latched events sit in a pending register that software clears by writing ones. An enable mask selects which pending bits reach the two interrupt request lines. One line serves pins 0 to 15 and the other serves pins 16 to 31.

Software reaches the block through a simple 32-bit register bus with two address windows. Window 0 holds the acceptance, enable, status and clear registers. Window 1 holds four packed detection-code registers. Writes take effect at the next clock edge. Reads are combinational from the address presented.

To reprogram a pin safely, software first turns its acceptance off. It then rewrites the detection code, clears the pin's pending bit and turns acceptance back on. While acceptance is off, the block never latches an event. This holds even when the new code would match at once.

Top module: `gpio_irq_sense_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and both interrupt lines are low.
- R2: Window 0, offset 0x14 is a read/write acceptance mask. A pin whose acceptance bit is 0 never gains a new pending bit.
- R3: Writing ones to window 0, offset 0x18 sets enable bits, and writing ones to offset 0x1C clears them. A read at 0x1C returns the enable mask, and a read at 0x18 returns zero.
- R4: Window 0, offset 0x20 reads the raw pending bits. Offset 0x24 reads the pending bits ANDed with the enable mask.
- R5: Writing a 1 to bit n at window 0, offset 0x28 clears pending bit n, and writing a 0 leaves it alone. Reads of 0x28 return zero.
- R6: Window 1, offsets 0x00, 0x04, 0x08 and 0x0C are read/write code registers. Pin n uses the register at offset 4*(n/8) and the bit field [(n mod 8)*4 +: 4].
- R7: Code 8 detects a rising edge, code 9 a falling edge and code 12 either edge. An edge compares the pin with its value one clock earlier, and the pending bit shows one clock after the pin changes.
- R8: Code 10 (high level) and code 11 (low level) set the pending bit on every clock while the level holds. The bit therefore reappears on the clock right after a clear.
- R9: Codes 0 to 7 and 13 to 15 never set a pending bit.
- R10: Rewriting a code while that pin's acceptance is off never produces a pending bit.
- R11: The low interrupt line is the OR of masked bits 0 to 15, and the high line is the OR of masked bits 16 to 31. Both follow the register state with no further delay.
- R12: When a new event and a clear write hit the same bit on the same clock, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized GPIO input levels |
| bus_wr | input | 1 | Register write strobe |
| bus_win | input | 1 | Address window select (0 control, 1 detection codes) |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented window and offset |
| irq_lo | output | 1 | Interrupt request for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
A stale edge history, a misplaced code field or a wrong event/clear priority shows up in the raw status read on the clock right after the pin stimulus. The sweep gives every pin each of the sixteen codes in turn, one code per pin offset, so a field that lands on the wrong pin changes some pending bit within one clock. A fault in the enable or acceptance path shows up at once in the masked status and on the interrupt lines. The same fault also shows up as a pending bit that appears while acceptance is off.

// File: rtl/gis_pkg.sv
package gis_pkg;

    typedef enum logic [3:0] {
        SENSE_RISE = 4'd8,
        SENSE_FALL = 4'd9,
        SENSE_HIGH = 4'd10,
        SENSE_LOW  = 4'd11,
        SENSE_BOTH = 4'd12
    } sense_e;

    localparam logic [5:0] OFS_ACCEPT = 6'h14;
    localparam logic [5:0] OFS_EN_SET = 6'h18;
    localparam logic [5:0] OFS_EN_CLR = 6'h1C;
    localparam logic [5:0] OFS_RAW    = 6'h20;
    localparam logic [5:0] OFS_MASKED = 6'h24;
    localparam logic [5:0] OFS_CLEAR  = 6'h28;

    typedef struct packed {
        logic        wr;
        logic        win;
        logic [5:0]  addr;
        logic [31:0] data;
    } bus_req_t;

    // Detection decision for one pin given its code, current and previous level.
    function automatic logic sense_hit(logic [3:0] code, logic cur, logic prev);
        case (code)
            SENSE_RISE: sense_hit = cur & ~prev;
            SENSE_FALL: sense_hit = ~cur & prev;
            SENSE_HIGH: sense_hit = cur;
            SENSE_LOW:  sense_hit = ~cur;
            SENSE_BOTH: sense_hit = cur ^ prev;
            default:    sense_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gis_regfile.sv
module gis_regfile
    import gis_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int CODE_W  = 4,
    parameter int PER_REG = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_req_t                  req,
    input  logic [NPINS-1:0]          pend,
    output logic [NPINS-1:0]          accept,
    output logic [NPINS-1:0]          enable,
    output logic [NPINS-1:0]          clear,
    output logic [NPINS*CODE_W-1:0]   sense,
    output logic [31:0]               rdata
);
    localparam int NREG = NPINS / PER_REG;
    localparam int REGW = CODE_W * PER_REG;

    logic [NREG-1:0][REGW-1:0] code_reg;
    logic wr_ctl, wr_code;

    assign wr_ctl  = req.wr && !req.win;
    assign wr_code = req.wr && req.win && (req.addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            accept <= '0;
            enable <= '0;
        end else if (wr_ctl) begin
            case (req.addr)
                OFS_ACCEPT: accept <= req.data[NPINS-1:0];
                OFS_EN_SET: enable <= enable | req.data[NPINS-1:0];
                OFS_EN_CLR: enable <= enable & ~req.data[NPINS-1:0];
                default: ;
            endcase
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_code
        always_ff @(posedge clk) begin
            if (rst)
                code_reg[r] <= '0;
            else if (wr_code && (int'(req.addr[5:2]) == r))
                code_reg[r] <= req.data[REGW-1:0];
        end
    end

    assign sense = code_reg;
    assign clear = (wr_ctl && req.addr == OFS_CLEAR) ? req.data[NPINS-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (!req.win) begin
            case (req.addr)
                OFS_ACCEPT: rdata = 32'(accept);
                OFS_EN_CLR: rdata = 32'(enable);
                OFS_RAW:    rdata = 32'(pend);
                OFS_MASKED: rdata = 32'(pend & enable);
                default:    rdata = '0;
            endcase
        end else if (req.addr[1:0] == 2'b00) begin
            for (int r = 0; r < NREG; r++)
                if (int'(req.addr[5:2]) == r) rdata = 32'(code_reg[r]);
        end
    end

    p_enable_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && req.addr == OFS_EN_SET) |=>
            ((enable & $past(req.data[NPINS-1:0])) == $past(req.data[NPINS-1:0])));

    p_enable_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && req.addr == OFS_EN_CLR) |=>
            ((enable & $past(req.data[NPINS-1:0])) == '0));

endmodule

// File: rtl/gis_detect.sv
module gis_detect
    import gis_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int CODE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPINS-1:0]         pins,
    input  logic [NPINS*CODE_W-1:0]  sense,
    output logic [NPINS-1:0]         hit
);
    logic [NPINS-1:0] pin_q;

    // Edge history runs regardless of acceptance or code changes.
    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pins;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit[i] = sense_hit(sense[i*CODE_W +: CODE_W], pins[i], pin_q[i]);
    end

endmodule

// File: rtl/gis_pending.sv
module gis_pending #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] accept,
    input  logic [NPINS-1:0] clear,
    output logic [NPINS-1:0] pend
);
    logic [NPINS-1:0] evt;

    assign evt = hit & accept;

    // A fresh event outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clear) | evt;
    end

    p_accept_gate_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(accept)) == '0));

    p_event_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));

    p_clear_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (|(clear & ~evt)) |=> ((pend & $past(clear & ~evt)) == '0));

endmodule

// File: rtl/gpio_irq_sense_ctrl.sv
module gpio_irq_sense_ctrl
    import gis_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int CODE_W  = 4,
    parameter int PER_REG = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pin_in,
    input  logic        bus_wr,
    input  logic        bus_win,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_lo,
    output logic        irq_hi
);
    localparam int GRP = NPINS / 2;

    bus_req_t                  req;
    logic [NPINS-1:0]          accept, enable, clear, pend, hit, masked;
    logic [NPINS*CODE_W-1:0]   sense;

    assign req = '{wr: bus_wr, win: bus_win, addr: bus_addr, data: bus_wdata};

    gis_regfile #(.NPINS(NPINS), .CODE_W(CODE_W), .PER_REG(PER_REG)) u_regs (
        .clk(clk), .rst(rst), .req(req), .pend(pend),
        .accept(accept), .enable(enable), .clear(clear),
        .sense(sense), .rdata(bus_rdata)
    );

    gis_detect #(.NPINS(NPINS), .CODE_W(CODE_W)) u_detect (
        .clk(clk), .rst(rst), .pins(pin_in[NPINS-1:0]),
        .sense(sense), .hit(hit)
    );

    gis_pending #(.NPINS(NPINS)) u_pend (
        .clk(clk), .rst(rst), .hit(hit), .accept(accept),
        .clear(clear), .pend(pend)
    );

    assign masked = pend & enable;
    assign irq_lo = |masked[GRP-1:0];
    assign irq_hi = |masked[NPINS-1:GRP];

    p_irq_lo_r11: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (|(pend[GRP-1:0] & enable[GRP-1:0])));

    p_irq_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (|(pend[NPINS-1:GRP] & enable[NPINS-1:GRP])) |-> irq_hi);

endmodule

// File: tb/gpio_irq_sense_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_sense_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pin_in;
    logic        bus_wr, bus_win;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    gpio_irq_sense_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #2 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    logic [31:0]  m_pend, m_en, m_acc, m_prev;
    logic [127:0] m_code;

    function automatic logic hit_f(logic [3:0] c, logic cur, logic prev);
        case (c)
            4'd8:    return cur & ~prev;
            4'd9:    return ~cur & prev;
            4'd10:   return cur;
            4'd11:   return ~cur;
            4'd12:   return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] lfsr(logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One clock: model next state from inputs driven now, then advance.
    task automatic tick();
        logic [31:0] ev, clr, nacc, nen, npend;
        logic [127:0] ncode;
        ev = '0; clr = '0; nacc = m_acc; nen = m_en; ncode = m_code;
        for (int i = 0; i < 32; i++)
            ev[i] = hit_f(m_code[i*4 +: 4], pin_in[i], m_prev[i]);
        if (bus_wr && !bus_win) begin
            case (bus_addr)
                6'h14: nacc = bus_wdata;
                6'h18: nen  = m_en | bus_wdata;
                6'h1C: nen  = m_en & ~bus_wdata;
                6'h28: clr  = bus_wdata;
                default: ;
            endcase
        end else if (bus_wr && bus_win && bus_addr[1:0] == 2'b00 && bus_addr[5:2] < 4)
            ncode[32*bus_addr[5:2] +: 32] = bus_wdata;
        npend = (m_pend & ~clr) | (ev & m_acc);
        @(posedge clk);
        m_pend = npend; m_acc = nacc; m_en = nen; m_code = ncode; m_prev = pin_in;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(logic win, logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic rd(logic win, logic [5:0] a, output logic [31:0] d);
        bus_wr = 1'b0; bus_win = win; bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_state();
        logic [31:0] d, mk;
        mk = m_pend & m_en;
        rd(1'b0, 6'h20, d); chk("R4 R7 R8 R9 raw pending", d, m_pend);
        rd(1'b0, 6'h24, d); chk("R4 masked status", d, mk);
        rd(1'b0, 6'h1C, d); chk("R3 enable mask", d, m_en);
        chk("R11 irq_lo", {31'd0, irq_lo}, {31'd0, |mk[15:0]});
        chk("R11 irq_hi", {31'd0, irq_hi}, {31'd0, |mk[31:16]});
    endtask

    task automatic set_codes(int base);
        for (int r = 0; r < 4; r++) begin
            logic [31:0] v;
            for (int k = 0; k < 8; k++) v[k*4 +: 4] = 4'((base + r*8 + k) % 16);
            wr(1'b1, 6'(r*4), v);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, seed;
        rst = 1'b1; pin_in = '0; bus_wr = 1'b0; bus_win = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_pend = '0; m_en = '0; m_acc = '0; m_prev = '0; m_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(1'b0, 6'(a*4), d); chk("R1 control window after reset", d, 32'd0);
        end
        for (int r = 0; r < 4; r++) begin
            rd(1'b1, 6'(r*4), d); chk("R1 code window after reset", d, 32'd0);
        end
        chk("R1 irq lines after reset", {30'd0, irq_hi, irq_lo}, 32'd0);

        // R6: code register readback and write-only offsets reading zero
        for (int r = 0; r < 4; r++) wr(1'b1, 6'(r*4), 32'h1234_5678 ^ (32'h1111_1111 * r));
        for (int r = 0; r < 4; r++) begin
            rd(1'b1, 6'(r*4), d); chk("R6 code readback", d, 32'h1234_5678 ^ (32'h1111_1111 * r));
        end
        wr(1'b0, 6'h18, 32'hA5A5_0F0F);
        rd(1'b0, 6'h18, d); chk("R3 set offset reads zero", d, 32'd0);
        wr(1'b0, 6'h28, 32'hFFFF_FFFF);
        rd(1'b0, 6'h28, d); chk("R5 clear offset reads zero", d, 32'd0);
        wr(1'b0, 6'h1C, 32'hFFFF_FFFF);

        // Sweep: every pin through every code, in shifted per-pin order
        seed = 32'hACE1_2468;
        for (int base = 0; base < 16; base++) begin
            wr(1'b0, 6'h14, 32'd0);
            pin_in = seed; tick();
            set_codes(base);
            rd(1'b0, 6'h20, d); chk("R10 code change with acceptance off", d, m_pend);
            wr(1'b0, 6'h28, 32'hFFFF_FFFF);
            rd(1'b0, 6'h20, d); chk("R5 clear all", d, m_pend);
            pin_in = ~seed; tick();
            rd(1'b0, 6'h20, d); chk("R2 no latch with acceptance off", d, 32'd0);
            seed = lfsr(seed);
            wr(1'b0, 6'h18, seed);
            wr(1'b0, 6'h14, base[0] ? 32'hFFFF_FFFF : lfsr(seed));
            for (int s = 0; s < 24; s++) begin
                seed = lfsr(seed);
                pin_in = seed ^ {seed[15:0], seed[31:16]};
                if (s % 5 == 4)      wr(1'b0, 6'h28, lfsr(seed));
                else if (s % 7 == 6) wr(1'b0, 6'h1C, seed & 32'h0F0F_F0F0);
                else                 tick();
                check_state();
            end
        end

        // R12: rising edge and clear collide on pin 3
        wr(1'b0, 6'h14, 32'hFFFF_FFFF);
        wr(1'b1, 6'h00, 32'h0000_8000);
        pin_in = '0; tick();
        wr(1'b0, 6'h28, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0008;
        wr(1'b0, 6'h28, 32'h0000_0008);
        rd(1'b0, 6'h20, d); chk("R12 event beats clear", d & 32'h8, 32'h8);
        wr(1'b0, 6'h28, 32'h0000_0008);
        rd(1'b0, 6'h20, d); chk("R7 rise is single shot after clear", d & 32'h8, 32'h0);

        // R8: high level on pin 20 reasserts right after a clear
        wr(1'b1, 6'h08, 32'h000A_0000);
        pin_in = 32'h0010_0000; tick();
        wr(1'b0, 6'h28, 32'h0010_0000);
        rd(1'b0, 6'h20, d); chk("R8 level reasserts after clear", d & 32'h0010_0000, 32'h0010_0000);
        wr(1'b0, 6'h18, 32'h0010_0000);
        chk("R11 high line from pin 20", {31'd0, irq_hi}, 32'd1);
        check_state();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule